// File: doc/BRIEF.md
# Slot Cycle Limit Counter

This block is a per-slave timer that a bus arbiter uses to cut very long tenures short, such as a master issuing back-to-back bursts of undefined length, or a long burst to a slow slave. Each time the arbiter completes an arbitration, the timer loads a programmed slot length. It then counts down by one on every clock.

Once the count is used up, the timer asks for re-arbitration. The request is only presented while the current bus access is completing, so an access in progress is never cut in half.

A slot length of zero switches the limit off. The counter then stays idle and does not toggle. The slot length lives in a small configuration register that comes out of reset at its maximum value. A write to that register affects only the next load and never a count already running.

Top module: `slot_limit_timer`

## Requirements
- R1: After reset, `rearb_req` is 0 and the stored slot length is 255 (all ones). An arbitration with no prior configuration write therefore expires 255 cycles after its load edge.
- R2: The clock edge that samples `arb_done` high loads the stored slot length N (N > 0). After N further rising edges the slot is expired; after N-1 further edges it is not.
- R3: `rearb_req` is high only when the slot is expired and `access_end` is high in the same cycle. An expired slot with `access_end` held low never raises the request, for as long as that lasts.
- R4: The count stops at zero and does not wrap. An expired slot stays expired until the next `arb_done`, however many cycles pass.
- R5: A stored slot length of 0 makes a load disable the limit. `rearb_req` then stays 0 and the count holds its value until the next arbitration.
- R6: A configuration write (`cfg_we` high, value on `cfg_slot`) during a running count leaves that count unchanged. The new value is used from the next `arb_done` onward.
- R7: An `arb_done` while counting, or while expired, restarts the count from the stored length. `rearb_req` is 0 in the cycle after that edge.
- R8: When `cfg_we` and `arb_done` are sampled on the same edge, the load uses the previously stored value. The written value is used at the following load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the slot length register |
| cfg_slot | input | SLOT_W | New slot length, taken when `cfg_we` is high |
| arb_done | input | 1 | One-cycle strobe marking a completed arbitration |
| access_end | input | 1 | High in the cycle in which the current bus access completes |
| rearb_req | output | 1 | Request to re-arbitrate at the end of this access |

## Verification
The checker watches several rules on every cycle:
- the request is only ever raised together with `access_end`;
- a load copies the stored length;
- the count steps down by exactly one, or holds at zero;
- a disabled slot leaves the counter still;
- an arbitration always clears a pending expiry in the following cycle.

Some behaviour only the bench scenarios can show. These are the exact expiry cycle for a given length, the reset default of 255, and that a write made mid-count or on the arbitration edge is deferred to the next load. The bench also shows that a held-off access or a very long wait never produces a wrapped or spurious request.

// File: rtl/slot_limit_timer.sv
module slot_limit_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              arb_done,
  input  logic              access_end,
  output logic              rearb_req
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};
  localparam logic [SLOT_W-1:0] ZERO     = '0;
  localparam logic [SLOT_W-1:0] ONE      = {{(SLOT_W-1){1'b0}}, 1'b1};

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] cnt;
  logic              armed;
  logic              expired;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      slot_q <= SLOT_MAX;
    else if (cfg_we) slot_q <= cfg_slot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= ZERO;
      armed <= 1'b0;
    end else if (arb_done) begin
      cnt   <= slot_q;
      armed <= (slot_q != ZERO);
    end else if (armed && cnt != ZERO) begin
      cnt   <= cnt - ONE;
    end

  assign expired   = armed && (cnt == ZERO);
  assign rearb_req = expired && access_end;
endmodule

module slot_limit_timer_chk #(
  parameter int SLOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [SLOT_W-1:0] cfg_slot,
  input logic              arb_done,
  input logic              access_end,
  input logic              rearb_req,
  input logic [SLOT_W-1:0] slot_q,
  input logic [SLOT_W-1:0] cnt,
  input logic              armed
);
  assert_req_at_access_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rearb_req |-> access_end);

  assert_load_copies_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_done && slot_q != '0) |=> (armed && cnt == $past(slot_q)));

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !arb_done && cnt != '0) |=> (armed && cnt == $past(cnt) - 1'b1));

  assert_hold_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !arb_done && cnt == '0) |=> (armed && cnt == '0));

  assert_zero_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_done && slot_q == '0) |=> !armed);

  assert_idle_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arb_done) |=> (!armed && $stable(cnt)));

  assert_reload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_done |=> !rearb_req);

  assert_cfg_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> slot_q == $past(cfg_slot));
endmodule

bind slot_limit_timer slot_limit_timer_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
  .arb_done(arb_done), .access_end(access_end), .rearb_req(rearb_req),
  .slot_q(slot_q), .cnt(cnt), .armed(armed)
);

// File: tb/tb_slot_limit_timer.sv
module tb_slot_limit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_slot = '0;
  logic       arb_done = 1'b0;
  logic       access_end = 1'b0;
  logic       rearb_req;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  slot_limit_timer #(.SLOT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .arb_done(arb_done), .access_end(access_end), .rearb_req(rearb_req)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rearb_req actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_slot(logic [7:0] v);
    cfg_we = 1'b1; cfg_slot = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arbitrate();
    arb_done = 1'b1;
    @(negedge clk);
    arb_done = 1'b0;
  endtask

  task automatic expect_expiry(string req, int n);
    access_end = 1'b1;
    wait_n(n - 1);
    #1 check(req, rearb_req, 1'b0);
    wait_n(1);
    #1 check(req, rearb_req, 1'b1);
  endtask

  task automatic t_reset_default();
    access_end = 1'b1;
    #1 check("R1", rearb_req, 1'b0);
    arbitrate();
    expect_expiry("R1", 255);
  endtask

  task automatic t_basic_lengths();
    write_slot(8'd5);
    arbitrate();
    expect_expiry("R2", 5);
    write_slot(8'd1);
    arbitrate();
    expect_expiry("R2", 1);
  endtask

  task automatic t_deferred();
    write_slot(8'd3);
    access_end = 1'b0;
    arbitrate();
    wait_n(40);
    #1 check("R3", rearb_req, 1'b0);
    access_end = 1'b1;
    #1 check("R3", rearb_req, 1'b1);
    @(negedge clk);
    access_end = 1'b0;
    #1 check("R3", rearb_req, 1'b0);
  endtask

  task automatic t_saturate();
    access_end = 1'b1;
    wait_n(300);
    #1 check("R4", rearb_req, 1'b1);
  endtask

  task automatic t_zero_disable();
    write_slot(8'd0);
    arbitrate();
    access_end = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rearb_req !== 1'b0) begin
        check("R5", rearb_req, 1'b0);
        break;
      end
    end
    #1 check("R5", rearb_req, 1'b0);
  endtask

  task automatic t_mid_write();
    write_slot(8'd6);
    arbitrate();
    access_end = 1'b1;
    write_slot(8'd2);
    wait_n(4);
    #1 check("R6", rearb_req, 1'b0);
    wait_n(1);
    #1 check("R6", rearb_req, 1'b1);
    arbitrate();
    expect_expiry("R6", 2);
  endtask

  task automatic t_restart();
    write_slot(8'd4);
    arbitrate();
    access_end = 1'b1;
    wait_n(2);
    arbitrate();
    expect_expiry("R7", 4);
    arbitrate();
    #1 check("R7", rearb_req, 1'b0);
  endtask

  task automatic t_same_edge();
    write_slot(8'd7);
    arbitrate();
    cfg_we = 1'b1; cfg_slot = 8'd3; arb_done = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; arb_done = 1'b0;
    expect_expiry("R8", 7);
    arbitrate();
    expect_expiry("R8", 3);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_basic_lengths();
    t_deferred();
    t_saturate();
    t_zero_disable();
    t_mid_write();
    t_restart();
    t_same_edge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule